// File: doc/BRIEF.md
# Reload Timer Square-Wave Clock Generator

This block is a free-running timer whose count register reloads from a programmable value each time it passes its all-ones state. The block can drive a square wave onto an output pin from those reloads. A divide-by-two prescaler sits in front of the counter, so the counter advances once every two system clock cycles. In clock-generator mode the pin flips at every reload. One full output period is therefore four system cycles multiplied by the number of counts between the reload value and the wrap point. The output duty cycle is exactly half.

Software reaches the block through a byte-wide write port with three decoded slots. Slot 0 is a control byte. Slot 1 is the low byte of the reload value and slot 2 is its high byte. A separate run input starts and stops counting. While the run input is low, the counter keeps loading the reload value, so a new setting takes effect cleanly when the run input rises.

Each reload produces a one-cycle overflow strobe. A timer interrupt pulse also fires on a reload, but only when clock-generator mode is off. In clock-generator mode, reloads are kept away from the interrupt path. The clock-output rate and any other consumer of the overflow strobe share one reload value.

Top module: `clkout_timer`

## Requirements
- R1: After reset, `clk_pin`, `ovf_pulse` and `tmr_irq` are 0, both control bits are 0 and the reload value is 0.
- R2: While `run_en` is 0, the counter reloads from the reload value every cycle, no overflow occurs and `clk_pin` holds its level.
- R3: With reload value R and counter width W, the first overflow strobe follows 2*(2^W - R) rising edges after the edge that first samples `run_en` high.
- R4: Further overflows follow every 2*(2^W - R) cycles, and each `ovf_pulse` lasts exactly one cycle.
- R5: In clock-generator mode, `clk_pin` changes level in the cycle of each overflow strobe and at no other time. The first change after entering the mode goes to 1, so the pin is high for exactly half of each 4*(2^W - R) cycle period.
- R6: Clock-generator mode is active only when control bit 0 (external-count select) is 0 and control bit 1 (output enable) is 1. Otherwise `clk_pin` is 0 and its toggle state is cleared.
- R7: When control bit 0 is 1, the counter does not advance and no overflow occurs. External counting is not provided.
- R8: `tmr_irq` pulses together with `ovf_pulse` only when clock-generator mode is inactive. It never pulses in clock-generator mode.
- R9: A reload-value write made while running does not disturb the current count and applies from the next reload onward.
- R10: Write slot 0 sets the control byte (bit 0 external-count select, bit 1 output enable). Slot 1 is the reload low byte and slot 2 is the reload high byte. A write to slot 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | SEL_W (2) | Write slot select |
| wr_data | input | BYTE_W (8) | Write data byte |
| run_en | input | 1 | Run control: 1 counts, 0 stops and presets |
| clk_pin | output | 1 | Square-wave clock output |
| ovf_pulse | output | 1 | One-cycle strobe on each reload |
| tmr_irq | output | 1 | Timer interrupt pulse, suppressed in clock-generator mode |

## Verification
Assertions check the cycle-local rules on every cycle. The pin stays low outside clock-generator mode, and it changes level exactly when an overflow strobe appears. The interrupt never fires while the pin is being driven. Overflows are single-cycle, and they are absent while stopped or in external-count mode. The exact overflow cycle for a given reload value, the half-high duty measurement, the delayed effect of a reload write made while running, the ignored fourth write slot and the slowest-rate boundary at reload 0 depend on history across many cycles. Only the bench's scenarios with a scoreboard of predicted overflow times can show those.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

  // Control byte field positions decoded by the counter and pin stages.
  localparam int CTRL_EXT_BIT = 0;
  localparam int CTRL_OE_BIT  = 1;

  typedef struct packed {
    logic oe;   // square-wave output enable
    logic ext;  // external-count select (1 = no internal counting)
  } ctrl_t;

  // Slot numbering on the write port.
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_RELOAD_BASE = 1;

  function automatic logic clkgen_active(ctrl_t c);
    return c.oe && !c.ext;
  endfunction

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8,
  localparam int NB    = CNT_W / BYTE_W,
  localparam int SEL_W = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload
);

  logic [BYTE_W-1:0] rl_byte [NB];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (wr_en && wr_sel == SEL_W'(SLOT_CTRL)) begin
      ctrl.ext <= wr_data[CTRL_EXT_BIT];
      ctrl.oe  <= wr_data[CTRL_OE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) rl_byte[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NB; i++) begin
        if (wr_sel == SEL_W'(SLOT_RELOAD_BASE + i)) rl_byte[i] <= wr_data;
      end
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_pack
    assign reload[g*BYTE_W +: BYTE_W] = rl_byte[g];
  end

endmodule

// File: rtl/clkout_prescale.sv
module clkout_prescale #(
  parameter int DIV = 2,
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  if (DIV <= 1) begin : g_direct
    assign tick = run;
  end else begin : g_div
    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
        phase <= '0;
      end else if (phase == PW'(DIV - 1)) begin
        phase <= '0;
      end else begin
        phase <= phase + 1'b1;
      end
    end

    assign tick = run && (phase == PW'(DIV - 1));
  end

endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             adv,
  input  logic [CNT_W-1:0] reload,
  output logic             wrap
);

  logic [CNT_W-1:0] count;
  logic at_top;

  assign at_top = &count;
  assign wrap   = adv && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (!run) begin
      count <= reload;
    end else if (adv) begin
      count <= at_top ? reload : count + 1'b1;
    end
  end

endmodule

// File: rtl/clkout_pin.sv
module clkout_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wrap,
  output logic pin
);

  logic level;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      level <= 1'b0;
    end else if (wrap) begin
      level <= ~level;
    end
  end

  assign pin = active && level;

endmodule

// File: rtl/clkout_timer.sv
module clkout_timer
  import clkout_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int BYTE_W  = 8,
  parameter int PRE_DIV = 2,
  localparam int NB     = CNT_W / BYTE_W,
  localparam int SEL_W  = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              run_en,
  output logic              clk_pin,
  output logic              ovf_pulse,
  output logic              tmr_irq
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic             tick;
  logic             wrap;
  logic             gen_mode;
  logic             ext_sel;

  assign gen_mode = clkgen_active(ctrl_q);
  assign ext_sel  = ctrl_q.ext;

  clkout_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ctrl    (ctrl_q),
    .reload  (reload_q)
  );

  clkout_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run_en),
    .tick  (tick)
  );

  clkout_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_en),
    .adv    (tick && !ext_sel),
    .reload (reload_q),
    .wrap   (wrap)
  );

  clkout_pin u_pin (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (gen_mode),
    .wrap   (wrap),
    .pin    (clk_pin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_pulse <= 1'b0;
      tmr_irq   <= 1'b0;
    end else begin
      ovf_pulse <= wrap;
      tmr_irq   <= wrap && !gen_mode;
    end
  end

endmodule

// File: rtl/clkout_timer_chk.sv
module clkout_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic gen_mode,
  input logic ext_sel,
  input logic clk_pin,
  input logic ovf_pulse,
  input logic tmr_irq
);

  p_pin_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_mode |-> !clk_pin);

  p_irq_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gen_mode |-> !tmr_irq);

  p_irq_with_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> ovf_pulse);

  p_ovf_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  p_pin_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode && $past(gen_mode) && ovf_pulse) |-> (clk_pin != $past(clk_pin)));

  p_pin_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_mode && $past(gen_mode) && !ovf_pulse) |-> $stable(clk_pin));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !ovf_pulse);

  p_ext_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_sel |=> !ovf_pulse);

endmodule

bind clkout_timer clkout_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .gen_mode  (gen_mode),
  .ext_sel   (ext_sel),
  .clk_pin   (clk_pin),
  .ovf_pulse (ovf_pulse),
  .tmr_irq   (tmr_irq)
);

// File: tb/clkout_timer_bench.sv
`timescale 1ns/1ps
module clkout_timer_bench;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 2;
  localparam int FULL   = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [SEL_W-1:0] wr_sel = '0;
  logic [BYTE_W-1:0] wr_data = '0;
  logic run_en = 1'b0;
  logic clk_pin, ovf_pulse, tmr_irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hi_cnt = 0;
  bit count_hi = 1'b0;

  typedef struct {
    int at;
    int pin;
    int irq;
  } exp_t;
  exp_t sb[$];

  clkout_timer u_clkout_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .run_en    (run_en),
    .clk_pin   (clk_pin),
    .ovf_pulse (ovf_pulse),
    .tmr_irq   (tmr_irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops one predicted overflow per observed strobe.
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && count_hi && clk_pin) hi_cnt++;
    if (rst_n && ovf_pulse) begin
      if (sb.size() == 0) begin
        chk("R4 unexpected overflow", 1, 0);
      end else begin
        e = sb.pop_front();
        chk("R3 R4 overflow cycle", cyc, e.at);
        chk("R5 R6 pin level at overflow", int'(clk_pin), e.pin);
        chk("R8 interrupt at overflow", int'(tmr_irq), e.irq);
      end
    end
  end

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1'b1;
    wr_sel = SEL_W'(sel);
    wr_data = BYTE_W'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(int rl, int ctrl, bit poke3);
    run_en = 1'b0;
    wr(0, 0);
    wr(1, rl & 255);
    wr(2, (rl >> 8) & 255);
    wr(0, ctrl);
    if (poke3) wr(3, 0);
  endtask

  // Driver: configure, predict n overflows, run, stop.
  task automatic scenario(int rl, int n, int ctrl, bit poke3);
    int s, p;
    bit gen, adv;
    exp_t e;
    gen = (ctrl == 2);
    adv = ((ctrl & 1) == 0);
    setup(rl, ctrl, poke3);
    p = FULL - rl;
    s = cyc;
    if (adv) begin
      for (int k = 1; k <= n; k++) begin
        e.at = s + 2 * p * k;
        e.pin = gen ? (k % 2) : 0;
        e.irq = gen ? 0 : 1;
        sb.push_back(e);
      end
    end
    run_en = 1'b1;
    repeat (2 * p * n + 1) @(negedge clk);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 all predicted overflows seen", sb.size(), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int s;
    exp_t e;
    repeat (3) @(negedge clk);
    chk("R1 pin in reset", int'(clk_pin), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 pin after reset", int'(clk_pin), 0);
    chk("R1 overflow after reset", int'(ovf_pulse), 0);
    chk("R1 interrupt after reset", int'(tmr_irq), 0);

    // R5 R10: fastest rate, slot 3 write must not disturb anything.
    scenario(16'hFFFF, 4, 2, 1'b1);
    chk("R10 pin low after even overflow count", int'(clk_pin), 0);

    // R5 duty: period 64 cycles, pin high 32 per period.
    hi_cnt = 0;
    count_hi = 1'b1;
    scenario(16'hFFF0, 4, 2, 1'b0);
    count_hi = 1'b0;
    chk("R5 high cycles over two periods", hi_cnt, 64);

    // R6 R8: output disabled, interrupt pulses, pin stays low.
    scenario(16'hFF00, 3, 0, 1'b0);
    chk("R6 pin low when output disabled", int'(clk_pin), 0);

    // R7 R6: external-count select halts counting and gates the pin.
    scenario(16'hFFF8, 4, 3, 1'b0);
    chk("R7 pin low in external-count mode", int'(clk_pin), 0);

    // R9 R2: reload change while running; stop with pin high.
    setup(16'hFFF0, 2, 1'b0);
    s = cyc;
    e.irq = 0;
    e.at = s + 32; e.pin = 1; sb.push_back(e);
    e.at = s + 48; e.pin = 0; sb.push_back(e);
    e.at = s + 64; e.pin = 1; sb.push_back(e);
    run_en = 1'b1;
    wr(1, 8'hF8);
    while (cyc < s + 65) @(negedge clk);
    run_en = 1'b0;
    repeat (6) @(negedge clk);
    chk("R9 predicted overflows seen", sb.size(), 0);
    chk("R2 pin held high while stopped", int'(clk_pin), 1);
    chk("R2 no overflow while stopped", int'(ovf_pulse), 0);

    // R3: slowest rate, reload 0.
    scenario(0, 1, 2, 1'b0);
    chk("R3 pin high after single slow overflow", int'(clk_pin), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule